// File: doc/BRIEF.md
# Nibble Mailbox I/O Command Processor

This block is a small command engine that a host drives through a shared mailbox of sixteen 4-bit entries. The host fills the mailbox over a byte-wide port. It places a command code in entry 8 and any arguments in entries 9 to 15, then pulses `run`. The engine reads the code and carries out one command against four active-low 4-bit input ports and two 4-bit output ports. It writes its results back into the mailbox, then pulses `done`. The host collects the results by reading the mailbox.

The supported commands are:

- **Raw read**: reads the four switch ports and sets both output ports.
- **Rate latch**: loads four coinage settings and presents them to downstream coin logic.
- **Constant reply**: writes a fixed start-up reply.
- **Checksum**: adds up the seven argument entries.
- **Multiplexed scan**: reads a DIP-switch matrix in two passes. Output port A selects the matrix half. The first pass goes to even entries and the second pass to odd entries.

The sequencer runs these states in order: `ST_IDLE` → (`run`) → `ST_DECODE`. From `ST_DECODE` the next state is one of the following:

- `ST_RAW`, `ST_RATE`, `ST_CONST` or `ST_SUM`, each followed by `ST_DONE`.
- `ST_SCAN_SET` → `ST_SCAN_LO` → `ST_SCAN_HI` → `ST_DONE`.
- For an unknown code, directly `ST_DONE`.

`ST_DONE` always returns to `ST_IDLE`.

Top module: `nib_cmd_engine`

## Requirements
- R1: A host read of entry `host_addr` returns the stored nibble in bits 3:0 with bits 7:4 all ones. A host write while the engine is idle stores only bits 3:0 of `host_wdata`.
- R2: After reset, every mailbox entry reads 0, both output ports are 0, all four rate settings are 1, and `busy` and `done` are low.
- R3: Command code 1 (in entry 8) writes the inverted ports A, B, C and D into entries 0, 1, 2 and 3. It then loads output port A from entry 9 and output port B from entry 10. `done` is high in the third cycle after the edge that samples `run`.
- R4: Command code 2 loads `rate_coins0`, `rate_creds0`, `rate_coins1` and `rate_creds1` from entries 9, 10, 11 and 12 respectively. It leaves the mailbox unchanged. The rate outputs change only while a command is executing.
- R5: Command code 8 forms the unsigned sum of entries 9 through 15. Bits 7:4 of the sum go to entry 0 and bits 3:0 go to entry 1.
- R6: Command code 9 first sets output port A to 0, waits one cycle, and stores inverted ports A, B, C and D in entries 0, 2, 4 and 6. It then sets output port A to 1 and, one cycle later, stores the inverted ports in entries 1, 3, 5 and 7. `done` is high in the fifth cycle after `run` is sampled, and output port A ends at 1.
- R7: Command code 7 writes 0xE to entry 2 and 0x6 to entry 7, and changes no other entry or output.
- R8: Any other command code leaves the mailbox, both output ports and the rate settings unchanged. `done` still pulses, in the second cycle after `run` is sampled.
- R9: Each accepted `run` yields exactly one `done` pulse of one cycle. `busy` is high from the cycle after `run` is sampled through the `done` cycle. A `run` raised while `busy` is high is ignored.
- R10: A host write while `busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Mailbox entry for host read and write |
| host_wdata | input | 8 | Host write data (low nibble kept) |
| host_rdata | output | 8 | Entry contents, upper nibble forced to ones |
| run | input | 1 | Start strobe for the command in entry 8 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| in_a | input | 4 | Switch port A, active low |
| in_b | input | 4 | Switch port B, active low |
| in_c | input | 4 | Switch port C, active low |
| in_d | input | 4 | Switch port D, active low |
| out_a | output | 4 | Output port A, also the scan half select |
| out_b | output | 4 | Output port B |
| rate_coins0 | output | 4 | Slot 0 coins-per-credit setting |
| rate_creds0 | output | 4 | Slot 0 credits-per-coin setting |
| rate_coins1 | output | 4 | Slot 1 coins-per-credit setting |
| rate_creds1 | output | 4 | Slot 1 credits-per-coin setting |

## Verification
The `done` latency depends on the command:

- Raw read, rate latch, constant reply and checksum: three cycles after `run` is sampled.
- Multiplexed scan: five cycles.
- Unknown code: two cycles.

The bench counts falling edges from the one that drops `run` and checks the cycle in which `done` first appears against that table. The mailbox and output ports are compared only after that cycle. The bench models the DIP matrix as a multiplexer on `out_a[0]`. The stored scan values are therefore correct only if each capture happens a full cycle after the select has changed.

// File: rtl/nib_cmd_pkg.sv
package nib_cmd_pkg;

    localparam int NIB_W      = 4;
    localparam int MBOX_N     = 16;
    localparam int CMD_SLOT   = 8;
    localparam int ARG_FIRST  = 9;
    localparam int ARG_N      = MBOX_N - ARG_FIRST;
    localparam int RATE_N     = 4;
    localparam int PORT_N     = 4;

    localparam logic [NIB_W-1:0] OP_RAW   = 4'd1;
    localparam logic [NIB_W-1:0] OP_RATE  = 4'd2;
    localparam logic [NIB_W-1:0] OP_CONST = 4'd7;
    localparam logic [NIB_W-1:0] OP_SUM   = 4'd8;
    localparam logic [NIB_W-1:0] OP_SCAN  = 4'd9;

    localparam logic [NIB_W-1:0] CONST_SLOT2 = 4'hE;
    localparam logic [NIB_W-1:0] CONST_SLOT7 = 4'h6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RAW,
        ST_RATE,
        ST_CONST,
        ST_SUM,
        ST_SCAN_SET,
        ST_SCAN_LO,
        ST_SCAN_HI,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [NIB_W-1:0] creds1;
        logic [NIB_W-1:0] coins1;
        logic [NIB_W-1:0] creds0;
        logic [NIB_W-1:0] coins0;
    } rate_cfg_t;

endpackage

// File: rtl/nib_mailbox.sv
module nib_mailbox #(
    parameter int NW      = 4,
    parameter int ENTRIES = 16,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_we,
    input  logic [AW-1:0]         host_addr,
    input  logic [NW-1:0]         host_wdata,
    input  logic                  host_block,
    input  logic [ENTRIES-1:0]    eng_we,
    input  logic [ENTRIES*NW-1:0] eng_wdata,
    output logic [ENTRIES*NW-1:0] mb_flat
);

    logic host_go;
    assign host_go = host_we && !host_block;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [NW-1:0] cell_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (eng_we[g]) begin
                cell_q <= eng_wdata[g*NW +: NW];
            end else if (host_go && (host_addr == AW'(g))) begin
                cell_q <= host_wdata;
            end
        end

        assign mb_flat[g*NW +: NW] = cell_q;
    end

endmodule

// File: rtl/nib_sum_chain.sv
module nib_sum_chain #(
    parameter int NW    = 4,
    parameter int COUNT = 7,
    parameter int SW    = 2 * NW
) (
    input  logic [COUNT*NW-1:0] args,
    output logic [SW-1:0]       total
);

    logic [SW-1:0] part [COUNT+1];

    assign part[0] = '0;

    for (genvar g = 0; g < COUNT; g++) begin : g_add
        assign part[g+1] = part[g] + SW'(args[g*NW +: NW]);
    end

    assign total = part[COUNT];

endmodule

// File: rtl/nib_cmd_seq.sv
module nib_cmd_seq
    import nib_cmd_pkg::*;
#(
    parameter int NW      = 4,
    parameter int ENTRIES = 16,
    parameter int PORTS   = 4,
    parameter int NRATE   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [NW-1:0]         cmd,
    input  logic [NRATE*NW-1:0]   rate_args,
    input  logic [2*NW-1:0]       sum_val,
    input  logic [PORTS*NW-1:0]   ports_raw,
    output logic [ENTRIES-1:0]    eng_we,
    output logic [ENTRIES*NW-1:0] eng_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [NW-1:0]         out_a,
    output logic [NW-1:0]         out_b,
    output rate_cfg_t             rate_q
);

    seq_state_e state_q, state_d;

    logic [PORTS*NW-1:0] ports_inv;
    assign ports_inv = ~ports_raw;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                case (cmd)
                    OP_RAW:   state_d = ST_RAW;
                    OP_RATE:  state_d = ST_RATE;
                    OP_CONST: state_d = ST_CONST;
                    OP_SUM:   state_d = ST_SUM;
                    OP_SCAN:  state_d = ST_SCAN_SET;
                    default:  state_d = ST_DONE;
                endcase
            end
            ST_RAW:      state_d = ST_DONE;
            ST_RATE:     state_d = ST_DONE;
            ST_CONST:    state_d = ST_DONE;
            ST_SUM:      state_d = ST_DONE;
            ST_SCAN_SET: state_d = ST_SCAN_LO;
            ST_SCAN_LO:  state_d = ST_SCAN_HI;
            ST_SCAN_HI:  state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // registered outputs: ports and rate settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a  <= '0;
            out_b  <= '0;
            rate_q <= '{creds1: NW'(1), coins1: NW'(1),
                        creds0: NW'(1), coins0: NW'(1)};
        end else begin
            unique case (state_q)
                ST_RAW: begin
                    out_a <= rate_args[0 +: NW];
                    out_b <= rate_args[NW +: NW];
                end
                ST_RATE: begin
                    rate_q.coins0 <= rate_args[0*NW +: NW];
                    rate_q.creds0 <= rate_args[1*NW +: NW];
                    rate_q.coins1 <= rate_args[2*NW +: NW];
                    rate_q.creds1 <= rate_args[3*NW +: NW];
                end
                ST_SCAN_SET: out_a <= '0;
                ST_SCAN_LO:  out_a <= NW'(1);
                default: ;
            endcase
        end
    end

    // mailbox write-back
    always_comb begin
        eng_we    = '0;
        eng_wdata = '0;
        unique case (state_q)
            ST_RAW: begin
                for (int p = 0; p < PORTS; p++) begin
                    eng_we[p]              = 1'b1;
                    eng_wdata[p*NW +: NW]  = ports_inv[p*NW +: NW];
                end
            end
            ST_SCAN_LO: begin
                for (int p = 0; p < PORTS; p++) begin
                    eng_we[2*p]                = 1'b1;
                    eng_wdata[(2*p)*NW +: NW]  = ports_inv[p*NW +: NW];
                end
            end
            ST_SCAN_HI: begin
                for (int p = 0; p < PORTS; p++) begin
                    eng_we[2*p+1]                = 1'b1;
                    eng_wdata[(2*p+1)*NW +: NW]  = ports_inv[p*NW +: NW];
                end
            end
            ST_SUM: begin
                eng_we[0]            = 1'b1;
                eng_we[1]            = 1'b1;
                eng_wdata[0 +: NW]   = sum_val[NW +: NW];
                eng_wdata[NW +: NW]  = sum_val[0 +: NW];
            end
            ST_CONST: begin
                eng_we[2]              = 1'b1;
                eng_we[7]              = 1'b1;
                eng_wdata[2*NW +: NW]  = CONST_SLOT2;
                eng_wdata[7*NW +: NW]  = CONST_SLOT7;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/nib_cmd_engine.sv
module nib_cmd_engine
    import nib_cmd_pkg::*;
#(
    parameter int NW      = NIB_W,
    parameter int ENTRIES = MBOX_N,
    parameter int HOST_W  = 8,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              run,
    output logic              busy,
    output logic              done,
    input  logic [NW-1:0]     in_a,
    input  logic [NW-1:0]     in_b,
    input  logic [NW-1:0]     in_c,
    input  logic [NW-1:0]     in_d,
    output logic [NW-1:0]     out_a,
    output logic [NW-1:0]     out_b,
    output logic [NW-1:0]     rate_coins0,
    output logic [NW-1:0]     rate_creds0,
    output logic [NW-1:0]     rate_coins1,
    output logic [NW-1:0]     rate_creds1
);

    localparam int ARGS_LO = ARG_FIRST * NW;
    localparam int ARGS_HI = ENTRIES * NW - 1;
    localparam int RATE_HI = (ARG_FIRST + RATE_N) * NW - 1;

    logic [ENTRIES*NW-1:0]  mb_flat;
    logic [ENTRIES-1:0]     eng_we;
    logic [ENTRIES*NW-1:0]  eng_wdata;
    logic [2*NW-1:0]        sum_val;
    logic [PORT_N*NW-1:0]   ports_raw;
    rate_cfg_t              rate_q;

    assign ports_raw = {in_d, in_c, in_b, in_a};

    nib_mailbox #(.NW(NW), .ENTRIES(ENTRIES), .AW(AW)) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata[NW-1:0]),
        .host_block (busy),
        .eng_we     (eng_we),
        .eng_wdata  (eng_wdata),
        .mb_flat    (mb_flat)
    );

    nib_sum_chain #(.NW(NW), .COUNT(ENTRIES - ARG_FIRST), .SW(2*NW)) u_sum (
        .args  (mb_flat[ARGS_HI:ARGS_LO]),
        .total (sum_val)
    );

    nib_cmd_seq #(.NW(NW), .ENTRIES(ENTRIES), .PORTS(PORT_N), .NRATE(RATE_N)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cmd       (mb_flat[CMD_SLOT*NW +: NW]),
        .rate_args (mb_flat[RATE_HI:ARGS_LO]),
        .sum_val   (sum_val),
        .ports_raw (ports_raw),
        .eng_we    (eng_we),
        .eng_wdata (eng_wdata),
        .busy      (busy),
        .done      (done),
        .out_a     (out_a),
        .out_b     (out_b),
        .rate_q    (rate_q)
    );

    assign host_rdata  = {{(HOST_W-NW){1'b1}}, mb_flat[host_addr*NW +: NW]};
    assign rate_coins0 = rate_q.coins0;
    assign rate_creds0 = rate_q.creds0;
    assign rate_coins1 = rate_q.coins1;
    assign rate_creds1 = rate_q.creds1;

endmodule

// File: rtl/nib_cmd_engine_chk.sv
module nib_cmd_engine_chk #(
    parameter int NW     = 4,
    parameter int HOST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              busy,
    input logic              done,
    input logic [HOST_W-1:0] host_rdata,
    input logic [NW-1:0]     out_a,
    input logic [NW-1:0]     out_b,
    input logic [NW-1:0]     rate_coins0,
    input logic [NW-1:0]     rate_creds0,
    input logic [NW-1:0]     rate_coins1,
    input logic [NW-1:0]     rate_creds1
);

    AST_RDATA_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (host_rdata[HOST_W-1:NW] == '1)); // R1

    AST_RUN_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run) |=> (busy && !done)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9

    AST_PORTS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !run) |=> ($stable(out_a) && $stable(out_b))); // R8

    AST_RATE_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(rate_coins0) && $stable(rate_creds0)
                   && $stable(rate_coins1) && $stable(rate_creds1))); // R4

endmodule

bind nib_cmd_engine nib_cmd_engine_chk #(.NW(NW), .HOST_W(HOST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .busy        (busy),
    .done        (done),
    .host_rdata  (host_rdata),
    .out_a       (out_a),
    .out_b       (out_b),
    .rate_coins0 (rate_coins0),
    .rate_creds0 (rate_creds0),
    .rate_coins1 (rate_coins1),
    .rate_creds1 (rate_creds1)
);

// File: tb/nib_cmd_engine_bench.sv
module nib_cmd_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       run = 1'b0;
    logic       busy, done;
    logic [3:0] in_a, in_b, in_c, in_d;
    logic [3:0] out_a, out_b;
    logic [3:0] rate_coins0, rate_creds0, rate_coins1, rate_creds1;

    // switch matrix: out_a[0] selects which half is presented
    logic [3:0] lo_a = '0, lo_b = '0, lo_c = '0, lo_d = '0;
    logic [3:0] hi_a = '0, hi_b = '0, hi_c = '0, hi_d = '0;
    assign in_a = out_a[0] ? hi_a : lo_a;
    assign in_b = out_a[0] ? hi_b : lo_b;
    assign in_c = out_a[0] ? hi_c : lo_c;
    assign in_d = out_a[0] ? hi_d : lo_d;

    always #5 clk = ~clk;

    nib_cmd_engine u_nib_cmd_engine (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .run(run), .busy(busy), .done(done),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .out_a(out_a), .out_b(out_b),
        .rate_coins0(rate_coins0), .rate_creds0(rate_creds0),
        .rate_coins1(rate_coins1), .rate_creds1(rate_creds1)
    );

    int checks = 0;
    int errors = 0;

    logic [3:0] mdl [16];
    logic [3:0] m_out_a = '0, m_out_b = '0;
    logic [3:0] m_rate [4];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] half(input logic sel, input logic [3:0] lo,
                                        input logic [3:0] hi);
        return sel ? hi : lo;
    endfunction

    function automatic int due_cycles(input logic [3:0] cmd);
        case (cmd)
            4'd1, 4'd2, 4'd7, 4'd8: return 3;
            4'd9:                   return 5;
            default:                return 2;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] cmd);
        case (cmd)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd7: return "R7";
            4'd8: return "R5";
            4'd9: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic model_exec(input logic [3:0] cmd);
        logic [7:0] s;
        case (cmd)
            4'd1: begin
                mdl[0] = ~half(m_out_a[0], lo_a, hi_a);
                mdl[1] = ~half(m_out_a[0], lo_b, hi_b);
                mdl[2] = ~half(m_out_a[0], lo_c, hi_c);
                mdl[3] = ~half(m_out_a[0], lo_d, hi_d);
                m_out_a = mdl[9];
                m_out_b = mdl[10];
            end
            4'd2: begin
                for (int i = 0; i < 4; i++) m_rate[i] = mdl[9+i];
            end
            4'd7: begin
                mdl[2] = 4'hE;
                mdl[7] = 4'h6;
            end
            4'd8: begin
                s = '0;
                for (int i = 9; i < 16; i++) s = s + 8'(mdl[i]);
                mdl[0] = s[7:4];
                mdl[1] = s[3:0];
            end
            4'd9: begin
                mdl[0] = ~lo_a; mdl[2] = ~lo_b; mdl[4] = ~lo_c; mdl[6] = ~lo_d;
                mdl[1] = ~hi_a; mdl[3] = ~hi_b; mdl[5] = ~hi_c; mdl[7] = ~hi_d;
                m_out_a = 4'd1;
            end
            default: ;
        endcase
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        mdl[a] = d[3:0];
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            host_addr = 4'(a);
            #1;
            chk(req, $sformatf("entry %0d", a), 32'(host_rdata), {24'h0, 4'hF, mdl[a]});
        end
        chk(req, "out_a", 32'(out_a), 32'(m_out_a));
        chk(req, "out_b", 32'(out_b), 32'(m_out_b));
        chk(req, "rate",  {16'h0, rate_creds1, rate_coins1, rate_creds0, rate_coins0},
            {16'h0, m_rate[3], m_rate[2], m_rate[1], m_rate[0]});
    endtask

    // pulse run, measure the done latency, then compare everything
    task automatic run_cmd(input logic [3:0] cmd);
        int n;
        string rq;
        rq = req_of(cmd);
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(rq, "done latency", 32'(n), 32'(due_cycles(cmd)));
        model_exec(cmd);
        @(negedge clk);
        chk("R9", "done width", {31'h0, done}, 32'h0);
        chk("R9", "busy after done", {31'h0, busy}, 32'h0);
        check_all(rq);
    endtask

    task automatic set_cmd(input logic [3:0] cmd);
        host_wr(4'd8, {4'($urandom), cmd});
    endtask

    task automatic rand_inputs;
        lo_a = 4'($urandom); lo_b = 4'($urandom); lo_c = 4'($urandom); lo_d = 4'($urandom);
        hi_a = 4'($urandom); hi_b = 4'($urandom); hi_c = 4'($urandom); hi_d = 4'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] code;
        int n;
        int dones;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        for (int i = 0; i < 4; i++) m_rate[i] = 4'd1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2", "busy", {31'h0, busy}, 32'h0);
        chk("R2", "done", {31'h0, done}, 32'h0);
        check_all("R2");

        // R1: upper host bits dropped on write, forced on read
        host_wr(4'd15, 8'hA7);
        host_wr(4'd3, 8'h5C);
        check_all("R1");

        // R5: checksum at its maximum
        for (int i = 9; i < 16; i++) host_wr(4'(i), 8'h0F);
        set_cmd(4'd8);
        run_cmd(4'd8);

        // R7: constant reply
        set_cmd(4'd7);
        run_cmd(4'd7);

        // R4: rate latch
        host_wr(4'd9, 8'h03); host_wr(4'd10, 8'h0A);
        host_wr(4'd11, 8'h0C); host_wr(4'd12, 8'h05);
        set_cmd(4'd2);
        run_cmd(4'd2);

        // R8: unknown codes 0 and F
        set_cmd(4'd0);
        run_cmd(4'd0);
        set_cmd(4'd15);
        run_cmd(4'd15);

        // R3: raw read with out_a select low
        rand_inputs();
        host_wr(4'd9, 8'h06); host_wr(4'd10, 8'h09);
        set_cmd(4'd1);
        run_cmd(4'd1);

        // R6: scan with distinct halves
        lo_a = 4'h1; lo_b = 4'h2; lo_c = 4'h4; lo_d = 4'h8;
        hi_a = 4'hE; hi_b = 4'hD; hi_c = 4'hB; hi_d = 4'h7;
        set_cmd(4'd9);
        run_cmd(4'd9);

        // R9 / R10: run and host write raised while busy
        rand_inputs();
        set_cmd(4'd9);
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        host_we = 1'b1; host_addr = 4'd12; host_wdata = {4'h0, ~mdl[12]};
        run = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        run = 1'b0;
        n = 2;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "latency with run during busy", 32'(n), 32'd5);
        model_exec(4'd9);
        dones = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk("R9", "extra done pulses", 32'(dones), 32'd0);
        check_all("R10");

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            case ($urandom % 6)
                0: code = 4'd1;
                1: code = 4'd2;
                2: code = 4'd7;
                3: code = 4'd8;
                4: code = 4'd9;
                default: begin
                    code = 4'($urandom);
                    while (code == 4'd1 || code == 4'd2 || code == 4'd7 ||
                           code == 4'd8 || code == 4'd9)
                        code = 4'($urandom);
                end
            endcase
            for (int i = 9; i < 16; i++) host_wr(4'(i), 8'($urandom));
            set_cmd(code);
            rand_inputs();
            run_cmd(code);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule